// File: doc/BRIEF.md
# Interrupt Priority Register Bank and Resolver

This block stores a 3-bit priority for each of 30 interrupt lines and, every cycle, names the pending line that should be served first. Software reaches the priorities through a word-wide register bus with per-byte write enables. Each 32-bit register packs four priorities, one per byte lane, and only a privileged requester may read or write them. An unprivileged access changes nothing, reads back zero and raises a one-cycle error pulse.

The resolver is combinational. It takes the pending-and-enabled vector and a split control that says how many low bits of each priority count as subpriority, with the rest forming the group priority. The winner is the pending line with the smallest group priority. Among equal groups, the smallest subpriority wins, and any remaining tie goes to the lowest line number. The block reports a valid flag, the winning line number and the winner's group priority. Preemption against an active level, context saving and pending-bit upkeep belong to the surrounding controller.

Top module: `irq_prio_bank`

## Requirements
- R1: After reset every priority is zero, so every register reads back as zero.
- R2: Line 4n+k (k = 0..3) keeps its priority in bits 8k+7 down to 8k+5 of the register at byte offset 0x400 + 4n. Bits 8k+4 down to 8k read as zero, and the two lowest address bits are ignored.
- R3: A privileged write changes only the lanes whose byte enable (bit k for lane k) is set. The other lanes keep their values.
- R4: Lanes that carry no line (bits 31:16 at offset 0x41C) ignore writes and read zero. Offsets outside 0x400..0x41C ignore writes, read zero and raise no error.
- R5: An access with the privilege input low leaves every priority unchanged and returns zero read data. It raises the error output in the following cycle only. The error output is low in every other cycle.
- R6: Read data appears on the cycle after a privileged read. In any cycle that does not follow such a read, the read data output is zero.
- R7: The group output equals the winner's priority shifted right by the split value (0..3 subpriority bits, so split 3 always gives group 0).
- R8: The winner is pending. No pending line has a smaller group priority. Among equal groups, none has a smaller subpriority. Any remaining tie goes to the lowest line number.
- R9: With no line pending, the valid output is low and the number and group outputs are zero.
- R10: A priority written on a clock edge is used by the resolver from that edge on, in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_be | input | 4 | Byte enables, bit k for lane k (bits 8k+7:8k) |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Requester is privileged |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an unprivileged access |
| irq_pend | input | 30 | Pending and enabled lines, bit i for line i |
| sub_bits | input | 2 | Number of low priority bits treated as subpriority |
| win_valid | output | 1 | At least one line is pending |
| win_id | output | 5 | Number of the winning line |
| win_group | output | 3 | Group priority of the winner |

## Verification
A register write and a resolution can fall in the same cycle. The write moves a priority on the edge, and the resolver must rank the pending lines by the new value in the next cycle. The bench provokes this with a long stretch in which random privileged and unprivileged writes, random pending vectors and changing split values are driven on the same cycles. A behavioural model applies the write at the edge and then picks a winner by plain minimum search. Read data, the error pulse, the valid flag, the winning number and the group are compared with the model after every clock edge, so a stale or early priority shows up as a wrong winner in that same cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   localparam int LANE_BITS = 8;

   typedef enum int {
      RES_LINEAR = 0,
      RES_TREE   = 1
   } res_style_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // lexicographic order: group first, then subpriority; strict so ties keep the incumbent
   function automatic logic prio_beats(input logic [7:0] g_new, input logic [7:0] s_new,
                                       input logic [7:0] g_old, input logic [7:0] s_old);
      return (g_new < g_old) || ((g_new == g_old) && (s_new < s_old));
   endfunction

endpackage

// File: rtl/irq_prio_regfile.sv
module irq_prio_regfile
   import irq_prio_pkg::*;
#(
   parameter int               NUM_IRQ   = 30,
   parameter int               PRIO_W    = 3,
   parameter int               DATA_W    = 32,
   parameter int               ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h400
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_sel,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W/8-1:0]       bus_be,
   input  logic [DATA_W-1:0]         bus_wdata,
   input  logic                      bus_priv,
   output logic [DATA_W-1:0]         bus_rdata,
   output logic                      bus_err,
   output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);

   localparam int LANES     = DATA_W / LANE_BITS;
   localparam int NUM_REGS  = ceil_div(NUM_IRQ, LANES);
   localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int LANE_SH   = $clog2(LANES);
   localparam int FIELD_LSB = LANE_BITS - PRIO_W;
   localparam int BASE_WORD = int'(BASE_ADDR) >> LANE_SH;

   initial begin
      assert (DATA_W % LANE_BITS == 0 && LANES >= 1)
         else $fatal(1, "data width must be whole byte lanes");
      assert (PRIO_W >= 1 && PRIO_W <= LANE_BITS)
         else $fatal(1, "priority width must fit one lane");
      assert ((int'(BASE_ADDR) % LANES) == 0)
         else $fatal(1, "base address must be word aligned");
      assert (BASE_WORD + NUM_REGS <= (1 << (ADDR_W - LANE_SH)))
         else $fatal(1, "register window exceeds address space");
   end

   logic [ADDR_W-1:0] word_addr;
   logic              in_range;
   logic [IDX_W-1:0]  reg_idx;
   logic              granted;
   logic              wr_hit;
   logic              rd_hit;
   logic              deny;
   logic [DATA_W-1:0] rd_word;
   logic [PRIO_W-1:0] prio_q [NUM_IRQ];
   logic              unused_bits;

   assign word_addr = bus_addr >> LANE_SH;
   assign in_range  = (int'(word_addr) >= BASE_WORD) && (int'(word_addr) < BASE_WORD + NUM_REGS);
   assign reg_idx   = IDX_W'(int'(word_addr) - BASE_WORD);
   assign granted   = bus_sel && bus_priv && in_range;
   assign wr_hit    = granted && bus_wr;
   assign rd_hit    = granted && !bus_wr;
   assign deny      = bus_sel && !bus_priv;

   // storage: one flop field per line, nothing for reserved bits or absent lanes
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
      localparam int REG  = i / LANES;
      localparam int LANE = i % LANES;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[i] <= '0;
         end else if (wr_hit && (reg_idx == IDX_W'(REG)) && bus_be[LANE]) begin
            prio_q[i] <= bus_wdata[LANE*LANE_BITS + FIELD_LSB +: PRIO_W];
         end
      end
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
   end

   // read word assembly: fields land in the top of their lane, the rest stays zero
   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (reg_idx == IDX_W'(i / LANES)) begin
            rd_word[(i % LANES)*LANE_BITS + FIELD_LSB +: PRIO_W] = prio_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= rd_hit ? rd_word : '0;
         bus_err   <= deny;
      end
   end

   assign unused_bits = ^{bus_addr, bus_wdata};

   // reserved bit mask for the lower part of every lane
   function automatic logic [DATA_W-1:0] rsv_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int k = 0; k < LANES; k++) m[k*LANE_BITS +: FIELD_LSB] = '1;
      return m;
   endfunction

   a_r5_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_priv) |=> bus_err);
   a_r5_err_only: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_priv) |=> !bus_err);
   a_r5_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_priv) |=> $stable(prio_flat));
   a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_priv) |=> (bus_rdata == '0));
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> (bus_rdata == '0));
   a_r3_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && (bus_be == '0)) |=> $stable(prio_flat));
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rdata & rsv_mask()) == '0));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_prio_pkg::*;
#(
   parameter int PRIO_W = 3,
   parameter int ID_W   = 5
) (
   input  logic              a_vld,
   input  logic [ID_W-1:0]   a_id,
   input  logic [PRIO_W-1:0] a_grp,
   input  logic [PRIO_W-1:0] a_sub,
   input  logic              b_vld,
   input  logic [ID_W-1:0]   b_id,
   input  logic [PRIO_W-1:0] b_grp,
   input  logic [PRIO_W-1:0] b_sub,
   output logic              o_vld,
   output logic [ID_W-1:0]   o_id,
   output logic [PRIO_W-1:0] o_grp,
   output logic [PRIO_W-1:0] o_sub
);

   // side a always carries the lower line numbers, so a tie keeps a
   logic take_b;

   assign take_b = b_vld && (!a_vld ||
                   prio_beats(8'(b_grp), 8'(b_sub), 8'(a_grp), 8'(a_sub)));
   assign o_vld  = a_vld || b_vld;
   assign o_id   = take_b ? b_id  : a_id;
   assign o_grp  = take_b ? b_grp : a_grp;
   assign o_sub  = take_b ? b_sub : a_sub;

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_prio_pkg::*;
#(
   parameter int         NUM_IRQ   = 30,
   parameter int         PRIO_W    = 3,
   parameter res_style_e RES_STYLE = RES_TREE,
   localparam int        ID_W      = $clog2(NUM_IRQ),
   localparam int        SB_W      = $clog2(PRIO_W + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
   input  logic [NUM_IRQ-1:0]        pend,
   input  logic [SB_W-1:0]           sub_bits,
   output logic                      win_valid,
   output logic [ID_W-1:0]           win_id,
   output logic [PRIO_W-1:0]         win_group
);

   initial begin
      assert (NUM_IRQ >= 2) else $fatal(1, "at least two lines required");
      assert (PRIO_W >= 1 && PRIO_W <= 8) else $fatal(1, "priority width out of range");
   end

   logic [SB_W-1:0]   sb_eff;
   logic [PRIO_W-1:0] sub_mask;
   logic [PRIO_W-1:0] grp [NUM_IRQ];
   logic [PRIO_W-1:0] sub [NUM_IRQ];
   logic              best_vld;
   logic [ID_W-1:0]   best_id;
   logic [PRIO_W-1:0] best_grp;
   logic [PRIO_W-1:0] best_sub;

   assign sb_eff   = (int'(sub_bits) > PRIO_W) ? SB_W'(PRIO_W) : sub_bits;
   assign sub_mask = ~({PRIO_W{1'b1}} << sb_eff);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_split
      assign grp[i] = prio_flat[i*PRIO_W +: PRIO_W] >> sb_eff;
      assign sub[i] = prio_flat[i*PRIO_W +: PRIO_W] & sub_mask;
   end

   if (RES_STYLE == RES_TREE) begin : g_tree
      localparam int LVL    = $clog2(NUM_IRQ);
      localparam int LEAVES = 1 << LVL;
      localparam int NODES  = 2 * LEAVES;

      logic              t_vld [1:NODES-1];
      logic [ID_W-1:0]   t_id  [1:NODES-1];
      logic [PRIO_W-1:0] t_grp [1:NODES-1];
      logic [PRIO_W-1:0] t_sub [1:NODES-1];

      for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
         if (j < NUM_IRQ) begin : g_real
            assign t_vld[LEAVES+j] = pend[j];
            assign t_id[LEAVES+j]  = ID_W'(j);
            assign t_grp[LEAVES+j] = grp[j];
            assign t_sub[LEAVES+j] = sub[j];
         end else begin : g_pad
            assign t_vld[LEAVES+j] = 1'b0;
            assign t_id[LEAVES+j]  = '0;
            assign t_grp[LEAVES+j] = '0;
            assign t_sub[LEAVES+j] = '0;
         end
      end

      for (genvar n = 1; n < LEAVES; n++) begin : g_node
         irq_prio_pick #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
            .a_vld (t_vld[2*n]),   .a_id (t_id[2*n]),
            .a_grp (t_grp[2*n]),   .a_sub(t_sub[2*n]),
            .b_vld (t_vld[2*n+1]), .b_id (t_id[2*n+1]),
            .b_grp (t_grp[2*n+1]), .b_sub(t_sub[2*n+1]),
            .o_vld (t_vld[n]),     .o_id (t_id[n]),
            .o_grp (t_grp[n]),     .o_sub(t_sub[n])
         );
      end

      assign best_vld = t_vld[1];
      assign best_id  = t_id[1];
      assign best_grp = t_grp[1];
      assign best_sub = t_sub[1];
   end else begin : g_linear
      always_comb begin
         best_vld = 1'b0;
         best_id  = '0;
         best_grp = '0;
         best_sub = '0;
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && (!best_vld ||
                prio_beats(8'(grp[i]), 8'(sub[i]), 8'(best_grp), 8'(best_sub)))) begin
               best_vld = 1'b1;
               best_id  = ID_W'(i);
               best_grp = grp[i];
               best_sub = sub[i];
            end
         end
      end
   end

   assign win_valid = best_vld;
   assign win_id    = best_vld ? best_id  : '0;
   assign win_group = best_vld ? best_grp : '0;

   // checks against the raw stored priorities, not the split path
   logic [PRIO_W-1:0] win_prio;
   assign win_prio = prio_flat[int'(win_id)*PRIO_W +: PRIO_W];

   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> (!win_valid && win_id == '0 && win_group == '0));
   a_r8_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> pend[win_id]);
   a_r8_valid_any: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |-> win_valid);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
      a_r8_none_better: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && pend[i]) |-> (prio_flat[i*PRIO_W +: PRIO_W] >= win_prio));
      a_r8_low_number: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && pend[i] && (ID_W'(i) < win_id)) |->
         (prio_flat[i*PRIO_W +: PRIO_W] > win_prio));
   end

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
   import irq_prio_pkg::*;
#(
   parameter int                NUM_IRQ   = 30,
   parameter int                PRIO_W    = 3,
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h400,
   parameter res_style_e        RES_STYLE = RES_TREE,
   localparam int               ID_W      = $clog2(NUM_IRQ),
   localparam int               SB_W      = $clog2(PRIO_W + 1),
   localparam int               BE_W      = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BE_W-1:0]    bus_be,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_priv,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_err,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [SB_W-1:0]    sub_bits,
   output logic               win_valid,
   output logic [ID_W-1:0]    win_id,
   output logic [PRIO_W-1:0]  win_group
);

   logic [NUM_IRQ*PRIO_W-1:0] prio_flat;

   irq_prio_regfile #(
      .NUM_IRQ  (NUM_IRQ),
      .PRIO_W   (PRIO_W),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_be   (bus_be),
      .bus_wdata(bus_wdata),
      .bus_priv (bus_priv),
      .bus_rdata(bus_rdata),
      .bus_err  (bus_err),
      .prio_flat(prio_flat)
   );

   irq_prio_resolver #(
      .NUM_IRQ  (NUM_IRQ),
      .PRIO_W   (PRIO_W),
      .RES_STYLE(RES_STYLE)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .prio_flat(prio_flat),
      .pend     (irq_pend),
      .sub_bits (sub_bits),
      .win_valid(win_valid),
      .win_id   (win_id),
      .win_group(win_group)
   );

   // R10: the resolver reads the live flops, so an edge write is ranked in the next cycle
   a_r10_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && irq_pend[win_id]) |-> (win_group == (prio_flat[int'(win_id)*PRIO_W +: PRIO_W] >> sub_bits)));

endmodule

// File: tb/irq_prio_bank_bench.sv
`timescale 1ns/1ps
module irq_prio_bank_bench;

   localparam int NIRQ = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_priv = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [29:0] irq_pend = '0;
   logic [1:0]  sub_bits = '0;
   logic        win_valid;
   logic [4:0]  win_id;
   logic [2:0]  win_group;

   irq_prio_bank u_irq_prio_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .irq_pend(irq_pend), .sub_bits(sub_bits), .win_valid(win_valid),
      .win_id(win_id), .win_group(win_group)
   );

   always #2 clk = ~clk;   // 250 MHz

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    finished = 0;
   string cur_tag  = "R1";
   int    mprio [NIRQ];
   logic [31:0] exp_rdata;
   logic        exp_err;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv,
                      input string what);
      n_checks++;
      if (act !== expv) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   function automatic bit in_window(input logic [11:0] a);
      return (a[11:2] >= 10'h100) && (a[11:2] <= 10'h107);
   endfunction

   function automatic logic [31:0] model_word(input int idx);
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < 4; k++) begin
         if (idx*4 + k < NIRQ) w[8*k+5 +: 3] = 3'(mprio[idx*4+k]);
      end
      return w;
   endfunction

   // reference model, evaluated on every edge
   always @(posedge clk) begin
      logic [31:0] nxt_rd;
      logic        nxt_err;
      int          idx;
      int          best;
      int          bestp;
      idx     = int'(bus_addr[11:2]) - 'h100;
      nxt_err = bus_sel && !bus_priv;
      nxt_rd  = (bus_sel && !bus_wr && bus_priv && in_window(bus_addr)) ? model_word(idx) : 32'h0;
      if (!rst_n) begin
         for (int i = 0; i < NIRQ; i++) mprio[i] = 0;   // R1
         exp_rdata = '0;
         exp_err   = 1'b0;
      end else begin
         if (bus_sel && bus_wr && bus_priv && in_window(bus_addr)) begin
            for (int k = 0; k < 4; k++) begin
               if (bus_be[k] && idx*4 + k < NIRQ) mprio[idx*4+k] = int'(bus_wdata[8*k+5 +: 3]);
            end
         end
         exp_rdata = nxt_rd;
         exp_err   = nxt_err;
      end
      #1;
      chk({cur_tag, " R6 rdata"}, bus_rdata, exp_rdata, "read data");
      chk("R5 err", {31'h0, bus_err}, {31'h0, exp_err}, "error pulse");
      best  = -1;
      bestp = 99;
      for (int i = 0; i < NIRQ; i++) begin
         if (irq_pend[i] && mprio[i] < bestp) begin
            best  = i;
            bestp = mprio[i];
         end
      end
      if (best < 0) begin
         chk({cur_tag, " R9 idle"}, {23'h0, win_valid, win_id, win_group}, 32'h0, "valid/id/group");
      end else begin
         chk({cur_tag, " R8 winner"}, {26'h0, win_valid, win_id}, {26'h0, 1'b1, 5'(best)}, "valid/id");
         chk({cur_tag, " R7 group"}, {29'h0, win_group}, {29'h0, 3'(bestp >> sub_bits)}, "group");
      end
   end

   task automatic access(input bit wr, input logic [11:0] a, input logic [3:0] be,
                         input logic [31:0] d, input bit priv);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d; bus_priv = priv;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0; bus_be = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: everything reads zero after reset
      cur_tag = "R1";
      for (int n = 0; n < 8; n++) access(0, 12'h400 + 12'(4*n), 4'hF, 0, 1);

      // R2: field placement and reserved bits
      cur_tag = "R2";
      for (int n = 0; n < 8; n++) access(1, 12'h400 + 12'(4*n), 4'hF, 32'hA5C3_E17F ^ (32'(n) * 32'h1357_9BDF), 1);
      for (int n = 0; n < 8; n++) access(0, 12'h400 + 12'(4*n) + 12'(n % 4), 4'h0, 0, 1);

      // R3: byte enables
      cur_tag = "R3";
      access(1, 12'h404, 4'b0101, 32'hFFFF_FFFF, 1);
      access(0, 12'h404, 4'h0, 0, 1);
      access(1, 12'h404, 4'b1000, 32'h0, 1);
      access(0, 12'h404, 4'h0, 0, 1);
      access(1, 12'h408, 4'b0000, 32'h0, 1);
      access(0, 12'h408, 4'h0, 0, 1);

      // R4: absent lanes and out-of-window offsets
      cur_tag = "R4";
      access(1, 12'h41C, 4'hF, 32'hFFFF_FFFF, 1);
      access(0, 12'h41C, 4'h0, 0, 1);
      access(1, 12'h420, 4'hF, 32'h0, 1);
      access(1, 12'h3FC, 4'hF, 32'h0, 1);
      access(0, 12'h420, 4'h0, 0, 1);
      access(0, 12'h3FC, 4'h0, 0, 1);

      // R5: unprivileged accesses, back to back, then a privileged read
      cur_tag = "R5";
      access(1, 12'h400, 4'hF, 32'h0, 0);
      access(0, 12'h400, 4'h0, 0, 0);
      access(0, 12'h400, 4'h0, 0, 1);

      // R6: read followed by idle cycles
      cur_tag = "R6";
      access(0, 12'h410, 4'h0, 0, 1);
      repeat (3) @(negedge clk);

      // R8: all equal priorities, tie to lowest number
      cur_tag = "R8";
      for (int n = 0; n < 8; n++) access(1, 12'h400 + 12'(4*n), 4'hF, 32'h0, 1);
      @(negedge clk); irq_pend = 30'h3FFF_FFFF;
      @(negedge clk); irq_pend = 30'h2000_0000;
      @(negedge clk); irq_pend = 30'h0001_8000;
      // distinct priorities, then sweep the split
      for (int n = 0; n < 8; n++) access(1, 12'h400 + 12'(4*n), 4'hF, 32'h6080_C0E0 + 32'(n) * 32'h2020_2020, 1);
      cur_tag = "R7";
      for (int s = 0; s < 4; s++) begin
         @(negedge clk); sub_bits = 2'(s); irq_pend = 30'h2AAA_AAAA;
         @(negedge clk); irq_pend = 30'h1555_5555;
         @(negedge clk); irq_pend = 30'h3000_0003;
      end

      // R9: nothing pending
      cur_tag = "R9";
      @(negedge clk); irq_pend = '0;
      @(negedge clk);

      // R10: writes and resolution colliding on the same cycles
      cur_tag = "R10";
      for (int c = 0; c < 600; c++) begin
         @(negedge clk);
         irq_pend  = (c % 9 == 0) ? 30'h0 : 30'($urandom);
         sub_bits  = 2'($urandom % 4);
         bus_sel   = ($urandom % 3) != 0;
         bus_wr    = ($urandom % 2) != 0;
         bus_priv  = ($urandom % 5) != 0;
         bus_addr  = 12'h3F8 + 12'(4 * ($urandom % 11));
         bus_be    = 4'($urandom);
         bus_wdata = $urandom;
      end
      @(negedge clk);
      bus_sel = 1'b0; irq_pend = '0;
      repeat (2) @(negedge clk);
      finish_up();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_up();
      end
   end

endmodule